// File: doc/BRIEF.md
# Multi-View Aliased Vector Register File

This block is a register bank for a vector datapath. One physical array of 32 entries, each 64 bits wide, is reachable through three overlapping register namespaces: 32-bit single registers, 64-bit double registers and 128-bit quad registers. There is no mode switch. Every access carries a two-bit width code, and that code alone chooses the namespace the index refers to. The same storage can therefore be written as a quad and read back as singles in the next cycle.

The bank has one write port and two independent read ports. Reads are combinational. Writes take effect at the rising clock edge. A narrow write changes only the bits it covers. A quad write updates two physical entries in one cycle. Illegal width codes and quad indices past the end of the quad namespace never disturb storage, and they read as zero.

Top module: `vrf_multiview`

## Requirements
- R1: Reset clears all 32 physical entries to zero, so every read of every view returns zero afterwards.
- R2: Width code 01 selects the double view. Index n reaches physical entry n. The read data occupies bits [63:0] and bits [127:64] are zero.
- R3: Width code 10 selects the quad view. Index n covers entries 2n (bits [63:0]) and 2n+1 (bits [127:64]), and a quad write updates both entries in the same clock edge.
- R4: Width code 00 selects the single view. Index k reaches entry k>>1, with even k mapping to bits [31:0] and odd k to bits [63:32]. Singles 0..31 therefore cover only entries 0..15. The read data sits in bits [31:0] and bits [127:32] are zero.
- R5: A single write changes only the addressed 32-bit half of one entry. The other half and all other entries keep their values.
- R6: A write through any view is visible through every other view that overlaps it, from the cycle after the write edge.
- R7: Reads are combinational. A read of bits being written in the same cycle returns the old value, and the new value appears after the edge.
- R8: Width code 11 is illegal. A write with it changes nothing, and a read with it returns zero.
- R9: A quad index of 16 or more is out of range. A write with it changes nothing, and a read with it returns zero.
- R10: The two read ports are independent and may use different views and indices in the same cycle.
- R11: With the write enable low, storage does not change whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_wid | input | 2 | Write width code (00 single, 01 double, 10 quad, 11 illegal) |
| wr_idx | input | 5 | Write register index in the chosen view |
| wr_data | input | 128 | Write data, right-aligned for narrow views |
| rd0_wid | input | 2 | Read port 0 width code |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_data | output | 128 | Read port 0 data, zero-extended |
| rd1_wid | input | 2 | Read port 1 width code |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_data | output | 128 | Read port 1 data, zero-extended |

## Verification
The assertions check on every cycle that un-enabled halves of each entry hold their value, that a legal quad write lands in both entries, that illegal codes and out-of-range quad indices read as zero, and that narrow reads keep their upper bits clear. The aliasing between namespaces, the read-before-write order within a cycle and the exact half a single index selects can only be shown by the bench's scenarios. The bench writes through each view and then sweeps every width code and index on both ports against an arithmetic model of the bank.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

   typedef enum logic [1:0] {
      VW_SGL  = 2'b00,
      VW_DBL  = 2'b01,
      VW_QUAD = 2'b10,
      VW_BAD  = 2'b11
   } vw_e;

endpackage

// File: rtl/vrf_wr_decode.sv
module vrf_wr_decode
   import vrf_pkg::*;
#(
   parameter int NUM_D = 32,
   parameter int D_W   = 64,
   localparam int H_W   = D_W / 2,
   localparam int Q_W   = 2 * D_W,
   localparam int IDX_W = $clog2(NUM_D)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [1:0]                    wr_wid,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [Q_W-1:0]                wr_data,
   output logic [NUM_D-1:0]              we_lo,
   output logic [NUM_D-1:0]              we_hi,
   output logic [NUM_D-1:0][H_W-1:0]     wd_lo,
   output logic [NUM_D-1:0][H_W-1:0]     wd_hi
);

   for (genvar e = 0; e < NUM_D; e++) begin : g_ent
      localparam logic [IDX_W-1:0] E_IDX  = IDX_W'(e);
      localparam logic [IDX_W-1:0] E_PAIR = IDX_W'(e / 2);
      localparam bit               E_ODD  = (e % 2) == 1;

      always_comb begin
         we_lo[e] = 1'b0;
         we_hi[e] = 1'b0;
         wd_lo[e] = wr_data[H_W-1:0];
         wd_hi[e] = wr_data[D_W-1:H_W];
         if (wr_en) begin
            case (vw_e'(wr_wid))
               VW_SGL: begin
                  if ({1'b0, wr_idx[IDX_W-1:1]} == E_IDX) begin
                     we_lo[e] = ~wr_idx[0];
                     we_hi[e] =  wr_idx[0];
                     wd_hi[e] = wr_data[H_W-1:0];
                  end
               end
               VW_DBL: begin
                  if (wr_idx == E_IDX) begin
                     we_lo[e] = 1'b1;
                     we_hi[e] = 1'b1;
                  end
               end
               VW_QUAD: begin
                  if (wr_idx == E_PAIR) begin
                     we_lo[e] = 1'b1;
                     we_hi[e] = 1'b1;
                     if (E_ODD) begin
                        wd_lo[e] = wr_data[D_W+H_W-1:D_W];
                        wd_hi[e] = wr_data[Q_W-1:D_W+H_W];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R5: a single write enables exactly one half of one entry
   a_r5_single_one_half: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_wid == 2'b00) |-> ($countones(we_lo) + $countones(we_hi)) == 1);

   // R8 / R11: no enable when the code is illegal or the write is off
   a_r8_bad_code_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_wid == 2'b11) |-> (we_lo == '0 && we_hi == '0));

endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
   parameter int NUM_D = 32,
   parameter int D_W   = 64,
   localparam int H_W  = D_W / 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_D-1:0]          we_lo,
   input  logic [NUM_D-1:0]          we_hi,
   input  logic [NUM_D-1:0][H_W-1:0] wd_lo,
   input  logic [NUM_D-1:0][H_W-1:0] wd_hi,
   output logic [NUM_D-1:0][D_W-1:0] ent
);

   for (genvar e = 0; e < NUM_D; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ent[e][H_W-1:0] <= '0;
         else if (we_lo[e]) ent[e][H_W-1:0] <= wd_lo[e];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ent[e][D_W-1:H_W] <= '0;
         else if (we_hi[e]) ent[e][D_W-1:H_W] <= wd_hi[e];
      end

      // R5 / R11: a half without its enable keeps its value
      a_r5_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !we_lo[e] |=> $stable(ent[e][H_W-1:0]));
      a_r5_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !we_hi[e] |=> $stable(ent[e][D_W-1:H_W]));
   end

   // R1: a reset cycle leaves the whole bank cleared
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> ent == '0);

endmodule

// File: rtl/vrf_rd_view.sv
module vrf_rd_view
   import vrf_pkg::*;
#(
   parameter int NUM_D = 32,
   parameter int D_W   = 64,
   localparam int H_W   = D_W / 2,
   localparam int Q_W   = 2 * D_W,
   localparam int NUM_Q = NUM_D / 2,
   localparam int IDX_W = $clog2(NUM_D)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                rd_wid,
   input  logic [IDX_W-1:0]          rd_idx,
   input  logic [NUM_D-1:0][D_W-1:0] ent,
   output logic [Q_W-1:0]            rd_data
);

   localparam logic [IDX_W:0] NUM_Q_L = (IDX_W+1)'(NUM_Q);

   logic [IDX_W-1:0] sgl_ent;
   logic [IDX_W-1:0] quad_lo;
   logic [IDX_W-1:0] quad_hi;
   logic             quad_ok;

   assign sgl_ent = {1'b0, rd_idx[IDX_W-1:1]};
   assign quad_lo = {rd_idx[IDX_W-2:0], 1'b0};
   assign quad_hi = {rd_idx[IDX_W-2:0], 1'b1};
   assign quad_ok = ({1'b0, rd_idx} < NUM_Q_L);

   always_comb begin
      rd_data = '0;
      case (vw_e'(rd_wid))
         VW_SGL:  rd_data = {{(Q_W-H_W){1'b0}},
                             rd_idx[0] ? ent[sgl_ent][D_W-1:H_W] : ent[sgl_ent][H_W-1:0]};
         VW_DBL:  rd_data = {{(Q_W-D_W){1'b0}}, ent[rd_idx]};
         VW_QUAD: if (quad_ok) rd_data = {ent[quad_hi], ent[quad_lo]};
         default: rd_data = '0;
      endcase
   end

   // R8: illegal code reads zero
   a_r8_bad_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wid == 2'b11 |-> rd_data == '0);
   // R4: single reads keep the upper bits clear
   a_r4_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wid == 2'b00 |-> rd_data[Q_W-1:H_W] == '0);
   // R2: double reads keep the upper half clear
   a_r2_double_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wid == 2'b01 |-> rd_data[Q_W-1:D_W] == '0);
   // R9: out-of-range quad reads zero
   a_r9_quad_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_wid == 2'b10 && rd_idx[IDX_W-1]) |-> rd_data == '0);

endmodule

// File: rtl/vrf_multiview.sv
module vrf_multiview
   import vrf_pkg::*;
#(
   parameter int NUM_D = 32,
   parameter int D_W   = 64,
   localparam int H_W    = D_W / 2,
   localparam int Q_W    = 2 * D_W,
   localparam int NUM_Q  = NUM_D / 2,
   localparam int IDX_W  = $clog2(NUM_D),
   localparam int NUM_RD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_wid,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [Q_W-1:0]   wr_data,
   input  logic [1:0]       rd0_wid,
   input  logic [IDX_W-1:0] rd0_idx,
   output logic [Q_W-1:0]   rd0_data,
   input  logic [1:0]       rd1_wid,
   input  logic [IDX_W-1:0] rd1_idx,
   output logic [Q_W-1:0]   rd1_data
);

   if (NUM_D < 4 || (NUM_D & (NUM_D - 1)) != 0) begin : g_bad_depth
      $error("NUM_D must be a power of two of at least 4");
   end
   if (D_W < 2 || (D_W % 2) != 0) begin : g_bad_width
      $error("D_W must be even");
   end

   logic [NUM_D-1:0]          we_lo;
   logic [NUM_D-1:0]          we_hi;
   logic [NUM_D-1:0][H_W-1:0] wd_lo;
   logic [NUM_D-1:0][H_W-1:0] wd_hi;
   logic [NUM_D-1:0][D_W-1:0] ent;

   logic [NUM_RD-1:0][1:0]       rp_wid;
   logic [NUM_RD-1:0][IDX_W-1:0] rp_idx;
   logic [NUM_RD-1:0][Q_W-1:0]   rp_data;

   assign rp_wid   = {rd1_wid, rd0_wid};
   assign rp_idx   = {rd1_idx, rd0_idx};
   assign rd0_data = rp_data[0];
   assign rd1_data = rp_data[1];

   vrf_wr_decode #(.NUM_D(NUM_D), .D_W(D_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_wid  (wr_wid),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .we_lo   (we_lo),
      .we_hi   (we_hi),
      .wd_lo   (wd_lo),
      .wd_hi   (wd_hi)
   );

   vrf_bank #(.NUM_D(NUM_D), .D_W(D_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we_lo (we_lo),
      .we_hi (we_hi),
      .wd_lo (wd_lo),
      .wd_hi (wd_hi),
      .ent   (ent)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      vrf_rd_view #(.NUM_D(NUM_D), .D_W(D_W)) u_view (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_wid  (rp_wid[p]),
         .rd_idx  (rp_idx[p]),
         .ent     (ent),
         .rd_data (rp_data[p])
      );
   end

   // Checker state: remember the last legal quad write
   logic             qw_v;
   logic [IDX_W-1:0] qw_lo;
   logic [Q_W-1:0]   qw_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qw_v    <= 1'b0;
         qw_lo   <= '0;
         qw_data <= '0;
      end else begin
         qw_v    <= wr_en && wr_wid == 2'b10 && !wr_idx[IDX_W-1];
         qw_lo   <= {wr_idx[IDX_W-2:0], 1'b0};
         qw_data <= wr_data;
      end
   end

   // R3: a legal quad write lands in both entries at one edge
   a_r3_quad_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      qw_v |-> {ent[qw_lo | IDX_W'(1)], ent[qw_lo]} == qw_data);

endmodule

// File: tb/vrf_multiview_tb.sv
module vrf_multiview_tb;

   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_wid = 2'b00;
   logic [4:0]   wr_idx = '0;
   logic [127:0] wr_data = '0;
   logic [1:0]   rd0_wid = 2'b01;
   logic [4:0]   rd0_idx = '0;
   logic [127:0] rd0_data;
   logic [1:0]   rd1_wid = 2'b01;
   logic [4:0]   rd1_idx = '0;
   logic [127:0] rd1_data;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [63:0] mdl [32];

   always #(CLK_P/2) clk = ~clk;

   vrf_multiview u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_wid(wr_wid), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd0_wid(rd0_wid), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
      .rd1_wid(rd1_wid), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
   );

   function automatic logic [127:0] expect_rd(input logic [1:0] w, input int i);
      logic [63:0] d;
      case (w)
         2'b00: begin
            d = mdl[i / 2];
            return (i % 2 == 1) ? {96'b0, d[63:32]} : {96'b0, d[31:0]};
         end
         2'b01: return {64'b0, mdl[i]};
         2'b10: return (i < 16) ? {mdl[2*i+1], mdl[2*i]} : 128'b0;
         default: return 128'b0;
      endcase
   endfunction

   function automatic string req_of(input logic [1:0] w, input int i);
      case (w)
         2'b00: return "R4/R6";
         2'b01: return "R2/R6";
         2'b10: return (i < 16) ? "R3/R6" : "R9";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [127:0] pat(input int i, input int salt);
      logic [31:0] b;
      b = 32'(salt) * 32'h9E37_79B9 + 32'(i) * 32'h0101_0101;
      return {b ^ 32'h1357_9BDF, b ^ 32'hF0E1_D2C3, b ^ 32'h0F1E_2D3C, b};
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic en, input logic [1:0] w, input int i,
                           input logic [127:0] d);
      @(negedge clk);
      wr_en   = en;
      wr_wid  = w;
      wr_idx  = 5'(i);
      wr_data = d;
      @(posedge clk);
      if (en) begin
         case (w)
            2'b00: if (i % 2 == 1) mdl[i/2][63:32] = d[31:0];
                   else            mdl[i/2][31:0]  = d[31:0];
            2'b01: mdl[i] = d[63:0];
            2'b10: if (i < 16) begin
                      mdl[2*i]   = d[63:0];
                      mdl[2*i+1] = d[127:64];
                   end
            default: ;
         endcase
      end
      #1 wr_en = 1'b0;
   endtask

   // Full sweep: port 0 walks every code and index, port 1 walks them reversed (R10)
   task automatic sweep(input string tag);
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
         for (int i = 0; i < 32; i++) begin
            rd0_wid = 2'(c);
            rd0_idx = 5'(i);
            rd1_wid = 2'(3 - c);
            rd1_idx = 5'(31 - i);
            #1;
            chk({tag, " ", req_of(2'(c), i)}, rd0_data, expect_rd(2'(c), i));
            chk({tag, " R10"}, rd1_data, expect_rd(2'(3 - c), 31 - i));
         end
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < 32; e++) mdl[e] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: everything reads zero after reset
      sweep("R1");

      // R2: fill through the double view
      for (int e = 0; e < 32; e++) do_write(1'b1, 2'b01, e, pat(e, 1));
      sweep("R2 fill");

      // R5: single writes touch one half only
      for (int k = 0; k < 32; k++) begin
         do_write(1'b1, 2'b00, k, pat(k, 2));
         @(negedge clk);
         rd0_wid = 2'b01; rd0_idx = 5'(k / 2);
         rd1_wid = 2'b00; rd1_idx = 5'(k ^ 1);
         #1;
         chk("R5 entry", rd0_data, expect_rd(2'b01, k / 2));
         chk("R5 other half", rd1_data, expect_rd(2'b00, k ^ 1));
      end
      sweep("R5 singles");

      // R3: quad writes update both entries in one edge
      for (int q = 0; q < 16; q++) begin
         do_write(1'b1, 2'b10, q, pat(q, 3));
         @(negedge clk);
         rd0_wid = 2'b01; rd0_idx = 5'(2 * q);
         rd1_wid = 2'b01; rd1_idx = 5'(2 * q + 1);
         #1;
         chk("R3 low entry", rd0_data, expect_rd(2'b01, 2 * q));
         chk("R3 high entry", rd1_data, expect_rd(2'b01, 2 * q + 1));
      end
      sweep("R3 quads");

      // R9: quad indices past 15 change nothing
      for (int q = 16; q < 32; q++) do_write(1'b1, 2'b10, q, pat(q, 4));
      sweep("R9 ignored");

      // R8: illegal width code changes nothing
      for (int i = 0; i < 32; i++) do_write(1'b1, 2'b11, i, pat(i, 5));
      sweep("R8 ignored");

      // R11: write enable low changes nothing
      for (int w = 0; w < 3; w++)
         for (int i = 0; i < 32; i += 5) do_write(1'b0, 2'(w), i, pat(i, 6));
      sweep("R11 idle");

      // R7: same-cycle read returns old value, new value after the edge
      @(negedge clk);
      wr_en = 1'b1; wr_wid = 2'b01; wr_idx = 5'd5; wr_data = pat(5, 7);
      rd0_wid = 2'b01; rd0_idx = 5'd5;
      rd1_wid = 2'b00; rd1_idx = 5'd11;
      #1;
      chk("R7 old double", rd0_data, expect_rd(2'b01, 5));
      chk("R7 old single", rd1_data, expect_rd(2'b00, 11));
      @(posedge clk);
      mdl[5] = wr_data[63:0];
      #1 wr_en = 1'b0;
      chk("R7 new double", rd0_data, expect_rd(2'b01, 5));
      chk("R7 new single", rd1_data, expect_rd(2'b00, 11));

      // R6: single write seen through the quad view
      do_write(1'b1, 2'b00, 31, 128'h0000_0000_0000_0000_0000_0000_CAFE_F00D);
      @(negedge clk);
      rd0_wid = 2'b10; rd0_idx = 5'd7;
      #1;
      chk("R6 quad alias", rd0_data, expect_rd(2'b10, 7));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule